// File: doc/BRIEF.md
# Conversion-Cycle Serial Output Controller

This block sequences one conversion per convert-start request and returns the result over a three-wire serial link that a host reads with its own serial clock. It sits between an abstract conversion engine and the host. On each falling edge of the active-low convert-start input it latches the channel-select level, issues a one-cycle start pulse to the engine, and drives the serial data line low to show that a conversion is in progress. When the engine returns a valid result, the line goes high to show that data is ready. After that, every falling edge of the host serial clock moves the line to the next result bit, most significant bit first.

The host raises convert-start when it has read the word. The line then returns to high impedance and the cycle ends. If the host raises convert-start before the full word has been read, the cycle is aborted. The line is held low for a short drain interval and then released. The convert-start and serial clock inputs are asynchronous to the system clock. Each passes through a synchronizer chain before its edges are detected. The serial data output is modelled as a data bit plus an output-enable, so that the high-impedance state can be observed directly.

Top module: `conv_serial_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the data line is enabled and driven high (sd_oe=1, sd_out=1). This holds until the first cycle starts, and no start pulse is issued in that time.
- R2: A falling edge on cs_n_in, seen while no cycle is active, produces exactly one eng_start pulse one clock wide. From that clock on, the line is enabled and driven low (busy).
- R3: eng_chan takes the level of chan_sel_in sampled when the cycle starts (0 = first source, 1 = second source). It keeps that value for the whole cycle, whatever chan_sel_in does later.
- R4: An eng_valid strobe during busy captures eng_word and drives the line high (ready).
- R5: Once the line is ready, each falling edge of sclk_in advances the line by one bit. Sampled before each rising edge, the line gives 1 and then eng_word from bit WORD_W-1 down to bit 0, which is WORD_W+1 pulses in all.
- R6: Falling edges of sclk_in that arrive before the ready indication are ignored and do not consume result bits.
- R7: When cs_n_in rises after all WORD_W+1 pulses, the line returns to high impedance (sd_oe=0) once the synchronizer latency has passed, with no extra delay.
- R8: When cs_n_in rises before all WORD_W+1 pulses, either during busy or during readout, the line stays enabled and driven low for ABORT_DLY clocks after the rise is detected. It then returns to high impedance.
- R9: An eng_valid strobe while no cycle is active (line in high impedance) has no effect: the line stays released, and the next cycle still reports busy until its own strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Active-low convert-start, asynchronous |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| chan_sel_in | input | 1 | Source select sampled at cycle start |
| eng_valid | input | 1 | Engine result strobe |
| eng_word | input | WORD_W | Engine result word |
| eng_start | output | 1 | One-clock start request to the engine |
| eng_chan | output | 1 | Source latched for the current cycle |
| sd_out | output | 1 | Serial data value |
| sd_oe | output | 1 | Serial data output enable (0 = high impedance) |

## Verification
The bench builds the block with WORD_W=6 and ABORT_DLY=3. A 64-value word space can be swept exhaustively for both source selections, so every bit position is seen at both levels in every slot of the readout. With the short drain interval, one sample point separates a clean end of cycle from an aborted one: at that point a clean end has already released the line, while an aborted cycle still drives it low. Aborts are exercised during busy and after a partial readout. The bench also covers early serial clocks and strobes arriving while the line is idle.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [2:0] {
    ST_PORHI = 3'd0,
    ST_IDLE  = 3'd1,
    ST_BUSY  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4,
    ST_DRAIN = 3'd5
  } csc_state_e;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign chain_d[i] = d;
    end else begin : g_next
      assign chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q    = chain_q[STAGES-1];
  assign rise = q & ~prev_q;
  assign fall = ~q & prev_q;
endmodule

// File: rtl/csc_shift.sv
module csc_shift #(
  parameter int WORD_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word,
  output logic              msb
);
  localparam int LEN = WORD_W + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = {1'b1, word};
    end else if (shift_en) begin
      sh_d = {sh_q[LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load || shift_en) begin
      sh_q <= sh_d;
    end
  end

  assign msb = sh_q[LEN-1];

  // R4
  ready_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> msb);
endmodule

// File: rtl/csc_fsm.sv
module csc_fsm
  import csc_pkg::*;
#(
  parameter int WORD_W    = 15,
  parameter int ABORT_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       sclk_fall,
  input  logic       eng_valid,
  input  logic       chan_in,
  output csc_state_e state,
  output logic       eng_start,
  output logic       eng_chan,
  output logic       load,
  output logic       shift_en
);
  localparam int CNT_MAX = (WORD_W > ABORT_DLY) ? WORD_W : ABORT_DLY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  csc_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic start_q, start_d;
  logic chan_q, chan_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    start_d  = 1'b0;
    chan_d   = chan_q;
    load     = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      ST_PORHI, ST_IDLE: begin
        if (cs_fall) begin
          state_d = ST_BUSY;
          cnt_d   = '0;
          start_d = 1'b1;
          chan_d  = chan_in;
        end
      end
      ST_BUSY: begin
        if (cs_rise) begin
          state_d = ST_DRAIN;
          cnt_d   = '0;
        end else if (eng_valid) begin
          state_d = ST_SHIFT;
          load    = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (cs_rise) begin
          state_d = ST_DRAIN;
          cnt_d   = '0;
        end else if (sclk_fall) begin
          shift_en = 1'b1;
          if (cnt_q == CNT_W'(WORD_W)) begin
            state_d = ST_DONE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (cs_rise) begin
          state_d = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (cnt_q == CNT_W'(ABORT_DLY - 1)) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PORHI;
      cnt_q   <= '0;
      start_q <= 1'b0;
      chan_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      chan_q  <= chan_d;
    end
  end

  assign state     = state_q;
  assign eng_start = start_q;
  assign eng_chan  = chan_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (state_q == ST_BUSY));
  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_q) |-> start_q);
  // R6
  early_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && sclk_fall && !eng_valid && !cs_rise) |=>
      (state_q == ST_BUSY && cnt_q == '0));
  // R5
  bit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (cnt_q <= CNT_W'(WORD_W)));
  // R8
  drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> (cnt_q < CNT_W'(ABORT_DLY)));
endmodule

// File: rtl/conv_serial_ctrl.sv
module conv_serial_ctrl
  import csc_pkg::*;
#(
  parameter int WORD_W      = 15,
  parameter int SYNC_STAGES = 2,
  parameter int ABORT_DLY   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_in,
  input  logic              sclk_in,
  input  logic              chan_sel_in,
  input  logic              eng_valid,
  input  logic [WORD_W-1:0] eng_word,
  output logic              eng_start,
  output logic              eng_chan,
  output logic              sd_out,
  output logic              sd_oe
);
  logic rst_meta_q, rst_core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  logic cs_lvl, cs_rise, cs_fall;
  logic sck_lvl, sck_rise, sck_fall;
  logic load, shift_en, msb;
  csc_state_e state;

  csc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_core_q), .d(cs_n_in),
    .q(cs_lvl), .rise(cs_rise), .fall(cs_fall));

  csc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_core_q), .d(sclk_in),
    .q(sck_lvl), .rise(sck_rise), .fall(sck_fall));

  csc_fsm #(.WORD_W(WORD_W), .ABORT_DLY(ABORT_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_core_q),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sck_fall),
    .eng_valid(eng_valid), .chan_in(chan_sel_in),
    .state(state), .eng_start(eng_start), .eng_chan(eng_chan),
    .load(load), .shift_en(shift_en));

  csc_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_core_q), .load(load), .shift_en(shift_en),
    .word(eng_word), .msb(msb));

  always_comb begin
    sd_oe = (state != ST_IDLE);
    unique case (state)
      ST_PORHI:           sd_out = 1'b1;
      ST_SHIFT, ST_DONE:  sd_out = msb;
      default:            sd_out = 1'b0;
    endcase
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_q)
    (!sd_oe && !cs_fall) |=> !sd_oe);
  // R1
  por_high_chk: assert property (@(posedge clk) disable iff (!rst_core_q)
    (sd_oe && sd_out && !cs_fall && !sck_fall && !sck_rise && !cs_lvl && !sck_lvl) |=> sd_oe);
endmodule

// File: tb/conv_serial_ctrl_tb_top.sv
module conv_serial_ctrl_tb_top;
  localparam int W   = 6;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_in = 1'b1;
  logic sclk_in = 1'b0;
  logic chan_sel_in = 1'b0;
  logic eng_valid = 1'b0;
  logic [W-1:0] eng_word = '0;
  logic eng_start, eng_chan, sd_out, sd_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  conv_serial_ctrl #(.WORD_W(W), .SYNC_STAGES(2), .ABORT_DLY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
    .chan_sel_in(chan_sel_in), .eng_valid(eng_valid), .eng_word(eng_word),
    .eng_start(eng_start), .eng_chan(eng_chan), .sd_out(sd_out), .sd_oe(sd_oe));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk_in = 1'b1; wait_n(4);
    sclk_in = 1'b0; wait_n(4);
  endtask

  task automatic start_cycle(input logic ch);
    bit seen = 1'b0;
    chan_sel_in = ch;
    wait_n(1);
    cs_n_in = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      wait_n(1);
      if (eng_start) seen = 1'b1;
    end
    check(seen, "R2 start pulse", int'(seen), 1);
    check(sd_oe && !sd_out, "R2 busy low", int'({sd_oe, sd_out}), 2);
    wait_n(1);
    check(!eng_start, "R2 pulse width", int'(eng_start), 0);
    chan_sel_in = ~ch;
  endtask

  task automatic give_result(input logic [W-1:0] w);
    eng_word = w; eng_valid = 1'b1;
    wait_n(1);
    eng_valid = 1'b0; eng_word = ~w;
    wait_n(3);
    check(sd_oe && sd_out, "R4 ready high", int'({sd_oe, sd_out}), 3);
  endtask

  task automatic full_cycle(input logic ch, input logic [W-1:0] w, input bit early);
    logic [W:0] exp = {1'b1, w};
    start_cycle(ch);
    if (early) begin
      sclk_pulse(); sclk_pulse();
      check(sd_oe && !sd_out, "R6 still busy", int'({sd_oe, sd_out}), 2);
    end
    give_result(w);
    for (int k = 0; k <= W; k++) begin
      check(sd_out == exp[W-k], early ? "R6 bit" : "R5 bit", int'(sd_out), int'(exp[W-k]));
      sclk_pulse();
    end
    check(eng_chan == ch, "R3 chan held", int'(eng_chan), int'(ch));
    cs_n_in = 1'b1;
    wait_n(4);
    check(!sd_oe, "R7 release", int'(sd_oe), 0);
  endtask

  task automatic abort_cycle(input int pulses, input bit ready);
    start_cycle(1'b0);
    if (ready) give_result(W'(6'h2A));
    for (int i = 0; i < pulses; i++) sclk_pulse();
    cs_n_in = 1'b1;
    wait_n(4);
    check(sd_oe && !sd_out, "R8 drain low", int'({sd_oe, sd_out}), 2);
    wait_n(4);
    check(!sd_oe, "R8 released", int'(sd_oe), 0);
  endtask

  initial begin
    wait_n(3);
    check(sd_oe && sd_out, "R1 during reset", int'({sd_oe, sd_out}), 3);
    rst_n = 1'b1;
    wait_n(6);
    check(sd_oe && sd_out, "R1 after reset", int'({sd_oe, sd_out}), 3);
    check(!eng_start, "R1 no start", int'(eng_start), 0);

    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < (1 << W); v++) begin
        full_cycle(c[0], W'(v), 1'b0);
      end
    end

    full_cycle(1'b1, W'(6'h15), 1'b1);
    full_cycle(1'b0, W'(6'h3C), 1'b1);

    abort_cycle(0, 1'b0);
    abort_cycle(3, 1'b1);
    abort_cycle(W, 1'b1);

    eng_word = W'(6'h11); eng_valid = 1'b1;
    wait_n(1);
    eng_valid = 1'b0;
    wait_n(4);
    check(!sd_oe, "R9 idle strobe", int'(sd_oe), 0);
    start_cycle(1'b1);
    wait_n(4);
    check(sd_oe && !sd_out, "R9 still busy", int'({sd_oe, sd_out}), 2);
    give_result(W'(6'h0F));
    cs_n_in = 1'b1;
    wait_n(10);
    full_cycle(1'b0, W'(6'h21), 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule